// File: doc/BRIEF.md
# Compressed-ISA Next-PC and Delay-Slot Sequencer

This block decides where a core running a 16-bit compressed instruction stream fetches next. Each accepted instruction arrives with its address and the control-transfer kind already decoded, plus the few operands a transfer needs: a general register value, the T8 register value and the immediate fields. Branches redirect the stream at once. Jumps first let one delay-slot instruction run at the following halfword, then redirect to their target.

The 32-bit absolute jump forms arrive as two halfwords over two accepted fetches. The sequencer records the first halfword's target fields, produces no next PC until the second halfword arrives, and then assembles the full target. While the delay-slot instruction runs, the block raises a slot flag. It also gives PC-relative operations the address of the jump that opened the slot rather than the slot's own address, aligned for word and for doubleword use. Register-indirect jump-and-link also asks for the return register to be written.

Top module: `cisa_pc_seq`

## Requirements
- R1: After a synchronous reset the block is outside any delay slot and has no absolute jump pending, `in_dslot` and `jump_illegal` are 0, and with `insn_valid` low `npc_valid` is 0.
- R2: An accepted instruction whose `xfer_kind` is 0 (none) or any code above 10 gives `next_pc = cur_pc + 2` with `npc_valid` high.
- R3: Kinds 1 (branch if `reg_val` is zero) and 2 (branch if `reg_val` is non-zero) use the sign-extended `br_imm[7:0]` shifted left by one. When taken, `next_pc = cur_pc + 2 + offset`; when not taken, `next_pc = cur_pc + 2`. There is no delay slot.
- R4: Kinds 3 (branch if `t8_val` is zero) and 4 (branch if `t8_val` is non-zero) behave as in R3 but test `t8_val`.
- R5: Kind 5 always branches to `cur_pc + 2` plus the sign-extended 11-bit `br_imm` shifted left by one, with no delay slot.
- R6: Kinds 6 (jump to register), 7 (return jump) and 8 (jump-and-link to register) give `next_pc = cur_pc + 2`. The next accepted instruction is the delay slot and has `in_dslot` high. That instruction yields `next_pc` equal to the `reg_val` captured at the jump, and the slot then ends.
- R7: Kind 8 also drives `ra_we` high for that cycle with `ra_val = cur_pc + 4`. `ra_we` is never high for any other kind.
- R8: Kinds 9 and 10 are absolute jumps taking two fetches. On the first halfword `npc_valid` is 0 and `jhi_fields` is captured. On the next accepted fetch `second_half` is used and `next_pc = P + 4`, where P is the first halfword's address. The target is bits 31:26 of P+4, then `jhi_fields[9:5]` in bits 25:21, `jhi_fields[4:0]` in bits 20:16, and `second_half` in bits 15:0. The delay slot that follows ends at this target.
- R9: Kind 10 builds the same target as kind 9 and then inverts its bit 0.
- R10: `pcrel_word` and `pcrel_dword` are a base address with its low two and low three bits cleared. The base is the saved jump address while `in_dslot` is high, and `cur_pc` otherwise.
- R11: A jump kind (6 to 10) accepted in a delay slot pulses `jump_illegal` for that cycle and writes no return address. Any instruction in the slot, including a branch, still ends the slot with `next_pc` at the saved target.
- R12: A cycle with `insn_valid` low gives `npc_valid` 0 and leaves the sequencer state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | A fetched halfword is present and accepted this cycle |
| cur_pc | input | 32 | Address of the accepted halfword |
| xfer_kind | input | 4 | Decoded control-transfer kind |
| br_imm | input | 11 | Branch immediate (low 8 bits for conditional forms) |
| jhi_fields | input | 10 | Absolute-jump target fields from the first halfword |
| second_half | input | 16 | Second halfword of an absolute jump |
| reg_val | input | 32 | General register operand |
| t8_val | input | 32 | T8 register value |
| npc_valid | output | 1 | `next_pc` is valid this cycle |
| next_pc | output | 32 | Address of the next fetch |
| ra_we | output | 1 | Write the return register |
| ra_val | output | 32 | Return address |
| in_dslot | output | 1 | The current instruction is a delay slot |
| pcrel_word | output | 32 | PC-relative base with the low 2 bits cleared |
| pcrel_dword | output | 32 | PC-relative base with the low 3 bits cleared |
| jump_illegal | output | 1 | A jump was found in a delay slot |

## Verification
The bench builds the block with its default 32-bit PC width. With that width, the rule that the absolute target keeps the upper six bits of the next PC can be checked with addresses whose top bits are all set. The bench sets the sign bit of each branch immediate to reach both maximum offsets. Directed sequences cover both halves of the absolute jump with idle cycles between them, and a long random stream mixes jumps inside delay slots with idle cycles.

// File: rtl/cisa_pkg.sv
package cisa_pkg;

    localparam int HALF_BYTES = 2;

    typedef enum logic [3:0] {
        XK_NONE  = 4'd0,
        XK_BEQZ  = 4'd1,
        XK_BNEZ  = 4'd2,
        XK_BT8Z  = 4'd3,
        XK_BT8NZ = 4'd4,
        XK_BRA   = 4'd5,
        XK_JREG  = 4'd6,
        XK_JRET  = 4'd7,
        XK_JLREG = 4'd8,
        XK_JABS  = 4'd9,
        XK_JABSX = 4'd10
    } xfer_e;

    typedef enum logic [1:0] {
        S_RUN  = 2'd0,
        S_WAIT = 2'd1,
        S_SLOT = 2'd2
    } seq_state_e;

    function automatic logic is_jump(input logic [3:0] k);
        return (k >= 4'd6) && (k <= 4'd10);
    endfunction

    function automatic logic is_abs(input logic [3:0] k);
        return (k == 4'd9) || (k == 4'd10);
    endfunction

endpackage

// File: rtl/cisa_branch_eval.sv
module cisa_branch_eval
    import cisa_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [3:0]      kind,
    input  logic [PC_W-1:0] pc,
    input  logic [10:0]     imm,
    input  logic [PC_W-1:0] gpr,
    input  logic [PC_W-1:0] t8,
    output logic [PC_W-1:0] br_next
);
    logic [PC_W-1:0] seq_pc;
    logic [PC_W-1:0] off;
    logic            taken;

    always_comb begin
        seq_pc = pc + PC_W'(HALF_BYTES);
        if (kind == XK_BRA)
            off = {{(PC_W-11){imm[10]}}, imm} << 1;
        else
            off = {{(PC_W-8){imm[7]}}, imm[7:0]} << 1;
        case (kind)
            XK_BEQZ:  taken = (gpr == '0);
            XK_BNEZ:  taken = (gpr != '0);
            XK_BT8Z:  taken = (t8 == '0);
            XK_BT8NZ: taken = (t8 != '0);
            XK_BRA:   taken = 1'b1;
            default:  taken = 1'b0;
        endcase
        br_next = taken ? (seq_pc + off) : seq_pc;
    end
endmodule

// File: rtl/cisa_abs_target.sv
module cisa_abs_target #(
    parameter int PC_W = 32
) (
    input  logic [PC_W-27:0] nia_top,
    input  logic [9:0]       hi_fields,
    input  logic [15:0]      lo_half,
    input  logic             flip_mode,
    output logic [PC_W-1:0]  target
);
    logic [PC_W-1:0] raw;

    always_comb begin
        raw    = {nia_top, hi_fields[9:5], hi_fields[4:0], lo_half};
        target = {raw[PC_W-1:1], raw[0] ^ flip_mode};
    end
endmodule

// File: rtl/cisa_pc_seq.sv
module cisa_pc_seq
    import cisa_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            insn_valid,
    input  logic [PC_W-1:0] cur_pc,
    input  logic [3:0]      xfer_kind,
    input  logic [10:0]     br_imm,
    input  logic [9:0]      jhi_fields,
    input  logic [15:0]     second_half,
    input  logic [PC_W-1:0] reg_val,
    input  logic [PC_W-1:0] t8_val,
    output logic            npc_valid,
    output logic [PC_W-1:0] next_pc,
    output logic            ra_we,
    output logic [PC_W-1:0] ra_val,
    output logic            in_dslot,
    output logic [PC_W-1:0] pcrel_word,
    output logic [PC_W-1:0] pcrel_dword,
    output logic            jump_illegal
);
    localparam int TOP_W = PC_W - 26;

    seq_state_e      state_q, state_d;
    logic [PC_W-1:0] jpc_q, jpc_d;
    logic [PC_W-1:0] tgt_q, tgt_d;
    logic [9:0]      hi_q, hi_d;
    logic            flip_q, flip_d;

    logic [PC_W-1:0] br_next;
    logic [PC_W-1:0] abs_tgt;
    logic [PC_W-1:0] nia;
    logic [PC_W-1:0] base;

    cisa_branch_eval #(.PC_W(PC_W)) u_br (
        .kind    (xfer_kind),
        .pc      (cur_pc),
        .imm     (br_imm),
        .gpr     (reg_val),
        .t8      (t8_val),
        .br_next (br_next)
    );

    assign nia = jpc_q + PC_W'(2 * HALF_BYTES);

    cisa_abs_target #(.PC_W(PC_W)) u_abs (
        .nia_top   (nia[PC_W-1:PC_W-TOP_W]),
        .hi_fields (hi_q),
        .lo_half   (second_half),
        .flip_mode (flip_q),
        .target    (abs_tgt)
    );

    always_comb begin
        state_d      = state_q;
        jpc_d        = jpc_q;
        tgt_d        = tgt_q;
        hi_d         = hi_q;
        flip_d       = flip_q;
        npc_valid    = 1'b0;
        next_pc      = '0;
        ra_we        = 1'b0;
        ra_val       = '0;
        jump_illegal = 1'b0;
        in_dslot     = (state_q == S_SLOT);
        if (insn_valid) begin
            case (state_q)
                S_RUN: begin
                    if (is_abs(xfer_kind)) begin
                        state_d = S_WAIT;
                        jpc_d   = cur_pc;
                        hi_d    = jhi_fields;
                        flip_d  = (xfer_kind == XK_JABSX);
                    end else if (is_jump(xfer_kind)) begin
                        npc_valid = 1'b1;
                        next_pc   = cur_pc + PC_W'(HALF_BYTES);
                        state_d   = S_SLOT;
                        jpc_d     = cur_pc;
                        tgt_d     = reg_val;
                        if (xfer_kind == XK_JLREG) begin
                            ra_we  = 1'b1;
                            ra_val = cur_pc + PC_W'(2 * HALF_BYTES);
                        end
                    end else begin
                        npc_valid = 1'b1;
                        next_pc   = br_next;
                    end
                end
                S_WAIT: begin
                    npc_valid = 1'b1;
                    next_pc   = nia;
                    tgt_d     = abs_tgt;
                    state_d   = S_SLOT;
                end
                default: begin
                    npc_valid    = 1'b1;
                    next_pc      = tgt_q;
                    jump_illegal = is_jump(xfer_kind);
                    state_d      = S_RUN;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_RUN;
            jpc_q   <= '0;
            tgt_q   <= '0;
            hi_q    <= '0;
            flip_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            jpc_q   <= jpc_d;
            tgt_q   <= tgt_d;
            hi_q    <= hi_d;
            flip_q  <= flip_d;
        end
    end

    assign base        = in_dslot ? jpc_q : cur_pc;
    assign pcrel_word  = {base[PC_W-1:2], 2'b00};
    assign pcrel_dword = {base[PC_W-1:3], 3'b000};

    p_illegal_only_in_slot_r11: assert property (@(posedge clk) disable iff (rst)
        jump_illegal |-> in_dslot);

    p_no_link_in_slot_r7: assert property (@(posedge clk) disable iff (rst)
        ra_we |-> !in_dslot);

    p_link_opens_slot_r6: assert property (@(posedge clk) disable iff (rst)
        ra_we |=> in_dslot);

    p_slot_lasts_one_r6: assert property (@(posedge clk) disable iff (rst)
        (in_dslot && insn_valid) |=> !in_dslot);

    p_abs_first_stalls_r8: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && state_q == S_RUN && is_abs(xfer_kind)) |-> !npc_valid);

    p_idle_no_npc_r12: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |-> !npc_valid);

    p_idle_holds_slot_r12: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |=> (in_dslot == $past(in_dslot)));

endmodule

// File: tb/test_cisa_pc_seq.sv
module test_cisa_pc_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        insn_valid = 1'b0;
    logic [31:0] cur_pc = '0;
    logic [3:0]  xfer_kind = '0;
    logic [10:0] br_imm = '0;
    logic [9:0]  jhi_fields = '0;
    logic [15:0] second_half = '0;
    logic [31:0] reg_val = '0;
    logic [31:0] t8_val = '0;
    logic        npc_valid, ra_we, in_dslot, jump_illegal;
    logic [31:0] next_pc, ra_val, pcrel_word, pcrel_dword;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    int          m_mode = 0;   // 0 run, 1 waiting for low half, 2 slot
    logic [31:0] m_jpc = '0;
    logic [31:0] m_tgt = '0;
    logic [9:0]  m_hi = '0;
    bit          m_flip = 0;

    always #4 clk = ~clk;

    cisa_pc_seq i_cisa_pc_seq (
        .clk(clk), .rst(rst), .insn_valid(insn_valid), .cur_pc(cur_pc),
        .xfer_kind(xfer_kind), .br_imm(br_imm), .jhi_fields(jhi_fields),
        .second_half(second_half), .reg_val(reg_val), .t8_val(t8_val),
        .npc_valid(npc_valid), .next_pc(next_pc), .ra_we(ra_we), .ra_val(ra_val),
        .in_dslot(in_dslot), .pcrel_word(pcrel_word), .pcrel_dword(pcrel_dword),
        .jump_illegal(jump_illegal)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one instruction slot: drive, compare against model, advance model
    task automatic step(input string req, input bit v, input logic [31:0] pc, input int k,
                        input logic [10:0] imm, input logic [9:0] hi, input logic [15:0] lo,
                        input logic [31:0] r, input logic [31:0] t);
        bit          e_v, e_we, e_ill, e_slot, tk;
        logic [31:0] e_npc, e_ra, b, off, raw;
        int          nm;
        @(negedge clk);
        insn_valid = v; cur_pc = pc; xfer_kind = 4'(k); br_imm = imm;
        jhi_fields = hi; second_half = lo; reg_val = r; t8_val = t;
        #1;
        e_v = 0; e_we = 0; e_ill = 0; e_npc = 0; e_ra = 0; nm = m_mode;
        e_slot = (m_mode == 2);
        b = e_slot ? m_jpc : pc;
        if (v) begin
            if (m_mode == 0) begin
                e_v = 1;
                if (k == 9 || k == 10) begin
                    e_v = 0; nm = 1; m_jpc = pc; m_hi = hi; m_flip = (k == 10);
                end else if (k >= 6 && k <= 8) begin
                    e_npc = pc + 2; nm = 2; m_jpc = pc; m_tgt = r;
                    if (k == 8) begin e_we = 1; e_ra = pc + 4; end
                end else begin
                    off = (k == 5) ? {{20{imm[10]}}, imm, 1'b0} : {{23{imm[7]}}, imm[7:0], 1'b0};
                    tk = (k == 1 && r == 0) || (k == 2 && r != 0) ||
                         (k == 3 && t == 0) || (k == 4 && t != 0) || (k == 5);
                    e_npc = tk ? pc + 2 + off : pc + 2;
                end
            end else if (m_mode == 1) begin
                e_v = 1; e_npc = m_jpc + 4;
                raw = {e_npc[31:26], m_hi, lo};
                if (m_flip) raw[0] = ~raw[0];
                m_tgt = raw; nm = 2;
            end else begin
                e_v = 1; e_npc = m_tgt; e_ill = (k >= 6 && k <= 10); nm = 0;
            end
        end
        chk(req, "npc_valid", {31'd0, npc_valid}, {31'd0, e_v});
        if (e_v) chk(req, "next_pc", next_pc, e_npc);
        chk("R7", "ra_we", {31'd0, ra_we}, {31'd0, e_we});
        if (e_we) chk("R7", "ra_val", ra_val, e_ra);
        chk(req, "in_dslot", {31'd0, in_dslot}, {31'd0, e_slot});
        chk("R10", "pcrel_word", pcrel_word, {b[31:2], 2'b00});
        chk("R10", "pcrel_dword", pcrel_dword, {b[31:3], 3'b000});
        chk("R11", "jump_illegal", {31'd0, jump_illegal}, {31'd0, e_ill});
        m_mode = nm;
    endtask

    initial begin : watchdog
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: reset state, idle
        step("R1", 0, 32'h0000_1000, 0, 0, 0, 0, 0, 0);
        // R2: sequential and unused kind codes
        step("R2", 1, 32'h0000_1000, 0, 0, 0, 0, 0, 0);
        step("R2", 1, 32'h0000_1002, 13, 11'h7FF, 0, 0, 0, 0);
        // R3: register branches
        step("R3", 1, 32'h0000_2000, 1, 11'h0FE, 0, 0, 0, 5);
        step("R3", 1, 32'h0000_2000, 1, 11'h07F, 0, 0, 7, 0);
        step("R3", 1, 32'h0000_2000, 2, 11'h080, 0, 0, 9, 0);
        step("R3", 1, 32'h0000_2000, 2, 11'h080, 0, 0, 0, 9);
        // R4: T8 branches
        step("R4", 1, 32'h0000_3000, 3, 11'h010, 0, 0, 1, 0);
        step("R4", 1, 32'h0000_3000, 3, 11'h010, 0, 0, 0, 1);
        step("R4", 1, 32'h0000_3000, 4, 11'h0F0, 0, 0, 0, 1);
        step("R4", 1, 32'h0000_3000, 4, 11'h0F0, 0, 0, 1, 0);
        // R5: unconditional, both extremes
        step("R5", 1, 32'h0000_4000, 5, 11'h3FF, 0, 0, 0, 0);
        step("R5", 1, 32'h0000_4000, 5, 11'h400, 0, 0, 0, 0);
        // R6/R12: register jump with idle cycle in the slot
        step("R6", 1, 32'h0000_5006, 6, 0, 0, 0, 32'h0000_9000, 0);
        step("R12", 0, 32'h0000_5008, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 32'h0000_5008, 0, 0, 0, 0, 0, 0);
        step("R6", 1, 32'h0000_6000, 7, 0, 0, 0, 32'h0000_7770, 0);
        step("R6", 1, 32'h0000_6002, 1, 11'h010, 0, 0, 0, 0);
        // R7: jump-and-link
        step("R7", 1, 32'h0000_4006, 8, 0, 0, 0, 32'h0001_0000, 0);
        step("R10", 1, 32'h0000_4008, 0, 0, 0, 0, 0, 0);
        // R8: absolute jump, top bits kept, idle between halves
        step("R8", 1, 32'hFC00_1234, 9, 0, 10'b10101_01010, 0, 0, 0);
        step("R12", 0, 32'h0, 0, 0, 0, 0, 0, 0);
        step("R8", 1, 32'hFC00_1236, 0, 0, 0, 16'hBEEF, 0, 0);
        step("R8", 1, 32'hFC00_1238, 0, 0, 0, 0, 0, 0);
        // R9: mode-switching absolute jump
        step("R9", 1, 32'h0800_0100, 10, 0, 10'b00001_11111, 0, 0, 0);
        step("R9", 1, 32'h0800_0102, 0, 0, 0, 16'h1230, 0, 0);
        step("R9", 1, 32'h0800_0104, 0, 0, 0, 0, 0, 0);
        // R11: jumps inside a slot
        step("R11", 1, 32'h0000_A000, 6, 0, 0, 0, 32'h0000_B000, 0);
        step("R11", 1, 32'h0000_A002, 8, 0, 0, 0, 32'h0000_C000, 0);
        step("R11", 1, 32'h0000_B000, 0, 0, 0, 0, 0, 0);
        step("R11", 1, 32'h0000_B002, 6, 0, 0, 0, 32'h0000_D000, 0);
        step("R11", 1, 32'h0000_B004, 9, 0, 0, 0, 0, 0);
        // random stream
        for (int i = 0; i < 2000; i++) begin
            logic [31:0] rpc;
            rpc = $urandom & 32'hFFFF_FFFE;
            step("R2", ($urandom_range(0, 9) != 0), rpc, $urandom_range(0, 12),
                 11'($urandom), 10'($urandom), 16'($urandom),
                 ($urandom_range(0, 2) == 0) ? 32'd0 : $urandom,
                 ($urandom_range(0, 2) == 0) ? 32'd0 : $urandom);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule